// File: doc/BRIEF.md
# Watchdog Reset Supervisor

This block is a clocked supervisor that owns one active-low reset output for a processor subsystem. It watches a supply-good flag, an active-low manual reset request, a watchdog enable and a watchdog kick line. All four inputs are asynchronous. Each passes through a two-flop synchroniser. The kick and the manual request must also stay at their level for a minimum number of clock cycles before they count.

After the supply becomes good, or after a manual request is released, the reset stays low for a full delay equal to the watchdog timeout. The reset then releases and the watchdog starts timing. A qualified rising edge on the kick line restarts the timeout. If the timeout runs out, the reset goes low for a short pulse of one tenth of the timeout, and a new timeout then begins. The enable input stops only the watchdog. Supply and manual-reset supervision keep working while it is inactive. A parameter selects whether the enable is active-high or active-low.

The state machine has four states:
- `ST_DOWN`: supply bad or manual reset active.
- `ST_HOLD`: full release delay.
- `ST_RUN`: reset released, watchdog timing.
- `ST_EXPIRE`: short reset pulse after a timeout.

The transitions are:
- Any state goes to `ST_DOWN` when the supply is bad or a manual request is active.
- `ST_DOWN` goes to `ST_HOLD` when both conditions clear.
- `ST_HOLD` goes to `ST_RUN` when the full delay ends.
- `ST_RUN` goes to `ST_EXPIRE` when the timeout ends.
- `ST_EXPIRE` goes to `ST_RUN` when the short pulse ends.

Top module: `wdt_supervisor`

## Requirements
- R1: When the synchronised supply-good flag is low, the reset output is driven low in every state. It goes low 3 clock edges after `supply_ok_i` falls.
- R2: After `supply_ok_i` rises, the reset output stays low and rises exactly TIMEOUT_TICKS+3 edges later.
- R3: Only a rising edge of the qualified kick restarts the timeout. A kick held high restarts it once, when it is first qualified, and never again. A qualified edge restarts the count 3+KICK_CYC edges after `kick_i` rises.
- R4: When the timeout expires without a kick, the reset goes low exactly TIMEOUT_TICKS edges after the count started. It stays low for TIMEOUT_TICKS/10 edges, and then a fresh timeout starts.
- R5: With `kick_i` held low, reset pulses repeat with a period of TIMEOUT_TICKS + TIMEOUT_TICKS/10 edges.
- R6: A qualified manual request drives the reset low 3+MR_CYC edges after `mrst_n_i` falls. After `mrst_n_i` returns high, the reset rises exactly TIMEOUT_TICKS+4 edges later.
- R7: While the watchdog enable is inactive, no timeout ever happens. Supply and manual-reset behaviour are unchanged.
- R8: When the enable becomes active with the reset released, a fresh timeout starts and expires TIMEOUT_TICKS+2 edges after the enable input changes. When supply and enable come up together, the full delay of R2 applies.
- R9: A kick high level shorter than KICK_CYC = ceil(KICK_MIN_NS/CLK_PERIOD_NS) cycles is ignored.
- R10: A manual low level shorter than MR_CYC = ceil(MR_MIN_NS/CLK_PERIOD_NS) cycles is ignored.
- R11: With EN_ACTIVE_HIGH=1, `wd_en_i`=1 enables the watchdog. With EN_ACTIVE_HIGH=0, `wd_en_i`=0 enables it.
- R12: While `arst_n` is low, the reset output is low and the state machine is in `ST_DOWN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset of the block's flops |
| supply_ok_i | input | 1 | Supply-good flag, 1 = supply above the detect level |
| kick_i | input | 1 | Watchdog kick, a rising edge restarts the timeout |
| mrst_n_i | input | 1 | Active-low manual reset request |
| wd_en_i | input | 1 | Watchdog enable, polarity set by EN_ACTIVE_HIGH |
| reset_n_o | output | 1 | Active-low reset to the supervised logic |

## Verification
The bench measures every release and assertion latency to the exact edge. It does this after a supply rise, after a manual release, after a timeout and after an enable change. These measurements separate the full delay from the short delay and confirm where a fresh timeout begins.

The kick line is driven several ways:
- left low, which shows pulses repeating;
- a pulse of exactly the qualifying width, which restarts the timeout;
- a pulse one cycle too short, which is ignored;
- a steady high level, which restarts the timeout only once.

Manual requests of one cycle below the qualifying width and at full length separate filtering from forcing. A second instance with the opposite enable polarity shows that the enable level is interpreted by the parameter.

// File: rtl/wdt_sup_pkg.sv
`timescale 1ns/1ps
package wdt_sup_pkg;

    typedef enum logic [1:0] {
        ST_DOWN   = 2'd0,
        ST_HOLD   = 2'd1,
        ST_RUN    = 2'd2,
        ST_EXPIRE = 2'd3
    } sup_state_e;

    function automatic int cycles_for_ns(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sync_2ff.sv
`timescale 1ns/1ps
module sync_2ff #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage1 <= RST_VAL;
            q_o    <= RST_VAL;
        end else begin
            stage1 <= d_i;
            q_o    <= stage1;
        end
    end
endmodule

// File: rtl/min_width_qual.sv
`timescale 1ns/1ps
module min_width_qual #(
    parameter int MIN_CYC = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic level_i,
    output logic qual_o
);
    localparam int CW = $clog2(MIN_CYC + 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            run_cnt <= '0;
            qual_o  <= 1'b0;
        end else if (!level_i) begin
            run_cnt <= '0;
            qual_o  <= 1'b0;
        end else if (run_cnt == CW'(MIN_CYC - 1)) begin
            qual_o  <= 1'b1;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_supervisor.sv
`timescale 1ns/1ps
module wdt_supervisor
    import wdt_sup_pkg::*;
#(
    parameter int TIMEOUT_TICKS  = 25000,
    parameter int CLK_PERIOD_NS  = 4,
    parameter int KICK_MIN_NS    = 100,
    parameter int MR_MIN_NS      = 1000,
    parameter bit EN_ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic supply_ok_i,
    input  logic kick_i,
    input  logic mrst_n_i,
    input  logic wd_en_i,
    output logic reset_n_o
);
    localparam int DLY1     = TIMEOUT_TICKS;
    localparam int DLY2     = (TIMEOUT_TICKS / 10 < 1) ? 1 : TIMEOUT_TICKS / 10;
    localparam int CNT_W    = $clog2(TIMEOUT_TICKS + 1);
    localparam int KICK_CYC = cycles_for_ns(KICK_MIN_NS, CLK_PERIOD_NS);
    localparam int MR_CYC   = cycles_for_ns(MR_MIN_NS, CLK_PERIOD_NS);

    // synchronised inputs: [3] supply, [2] kick, [1] manual (active low), [0] enable
    logic [3:0] raw_in;
    logic [3:0] syn_in;
    logic       sup_ok_s;
    logic       wd_on;
    logic       mr_act;
    logic       kick_q;
    logic       kick_q_d;
    logic       kick_edge;

    assign raw_in = {supply_ok_i, kick_i, mrst_n_i, wd_en_i};

    sync_2ff #(.W(4), .RST_VAL(4'b0010)) u_sync (
        .clk    (clk),
        .arst_n (arst_n),
        .d_i    (raw_in),
        .q_o    (syn_in)
    );

    assign sup_ok_s = syn_in[3];

    generate
        if (EN_ACTIVE_HIGH) begin : g_en_hi
            assign wd_on = syn_in[0];
        end else begin : g_en_lo
            assign wd_on = ~syn_in[0];
        end
    endgenerate

    min_width_qual #(.MIN_CYC(KICK_CYC)) u_kick_qual (
        .clk     (clk),
        .arst_n  (arst_n),
        .level_i (syn_in[2]),
        .qual_o  (kick_q)
    );

    min_width_qual #(.MIN_CYC(MR_CYC)) u_mr_qual (
        .clk     (clk),
        .arst_n  (arst_n),
        .level_i (~syn_in[1]),
        .qual_o  (mr_act)
    );

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) kick_q_d <= 1'b0;
        else         kick_q_d <= kick_q;
    end

    assign kick_edge = kick_q & ~kick_q_d;

    sup_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (!sup_ok_s || mr_act) begin
            state_n = ST_DOWN;
            cnt_n   = '0;
        end else begin
            unique case (state_q)
                ST_DOWN: begin
                    state_n = ST_HOLD;
                    cnt_n   = '0;
                end
                ST_HOLD: begin
                    if (cnt_q == CNT_W'(DLY1 - 1)) begin
                        state_n = ST_RUN;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (!wd_on || kick_edge) begin
                        cnt_n = '0;
                    end else if (cnt_q == CNT_W'(TIMEOUT_TICKS - 1)) begin
                        state_n = ST_EXPIRE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                ST_EXPIRE: begin
                    if (cnt_q == CNT_W'(DLY2 - 1)) begin
                        state_n = ST_RUN;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_n = ST_DOWN;
                    cnt_n   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= ST_DOWN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) reset_n_o <= 1'b0;
        else         reset_n_o <= (state_n == ST_RUN);
    end
endmodule

// File: rtl/wdt_supervisor_chk.sv
`timescale 1ns/1ps
module wdt_supervisor_chk
    import wdt_sup_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 25000
) (
    input logic       clk,
    input logic       arst_n,
    input logic       reset_n_o,
    input sup_state_e state_q,
    input logic       sup_ok_s,
    input logic       mr_act,
    input logic       wd_on
);
    localparam int DLY1 = TIMEOUT_TICKS;
    localparam int DLY2 = (TIMEOUT_TICKS / 10 < 1) ? 1 : TIMEOUT_TICKS / 10;

    int hold_len;
    int exp_len;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            hold_len <= 0;
            exp_len  <= 0;
        end else begin
            hold_len <= (state_q == ST_HOLD)   ? hold_len + 1 : 0;
            exp_len  <= (state_q == ST_EXPIRE) ? exp_len + 1  : 0;
        end
    end

    p_supply_override_r1: assert property (@(posedge clk) disable iff (!arst_n)
        !sup_ok_s |=> !reset_n_o);

    p_manual_forces_r6: assert property (@(posedge clk) disable iff (!arst_n)
        mr_act |=> !reset_n_o);

    p_hold_length_r2: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_RUN && $past(state_q) == ST_HOLD) |-> hold_len == DLY1);

    p_expire_length_r4: assert property (@(posedge clk) disable iff (!arst_n)
        (state_q == ST_RUN && $past(state_q) == ST_EXPIRE) |-> exp_len == DLY2);

    p_disabled_no_timeout_r7: assert property (@(posedge clk) disable iff (!arst_n)
        (!wd_on && reset_n_o && sup_ok_s && !mr_act) |=> reset_n_o);
endmodule

bind wdt_supervisor wdt_supervisor_chk #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_chk (
    .clk       (clk),
    .arst_n    (arst_n),
    .reset_n_o (reset_n_o),
    .state_q   (state_q),
    .sup_ok_s  (sup_ok_s),
    .mr_act    (mr_act),
    .wd_on     (wd_on)
);

// File: tb/wdt_supervisor_tb.sv
`timescale 1ns/1ps
module wdt_supervisor_tb;
    localparam int T  = 200;
    localparam int D2 = T / 10;
    localparam int KQ = 25;   // 100 ns at 4 ns
    localparam int MQ = 250;  // 1000 ns at 4 ns

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic supply_ok = 1'b0;
    logic kick = 1'b0;
    logic mrst_n = 1'b1;
    logic wd_en = 1'b1;
    logic rst_main;
    logic rst_inv;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    wdt_supervisor #(.TIMEOUT_TICKS(T), .CLK_PERIOD_NS(4), .EN_ACTIVE_HIGH(1'b1)) u_dut (
        .clk(clk), .arst_n(arst_n), .supply_ok_i(supply_ok), .kick_i(kick),
        .mrst_n_i(mrst_n), .wd_en_i(wd_en), .reset_n_o(rst_main));

    wdt_supervisor #(.TIMEOUT_TICKS(T), .CLK_PERIOD_NS(4), .EN_ACTIVE_HIGH(1'b0)) u_dut_inv (
        .clk(clk), .arst_n(arst_n), .supply_ok_i(supply_ok), .kick_i(kick),
        .mrst_n_i(mrst_n), .wd_en_i(wd_en), .reset_n_o(rst_inv));

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // counts clock edges until rst_main equals val (sampled at negedges)
    task automatic wait_level(input logic val, input int maxc, output int n);
        bit done;
        done = 1'b0;
        n = 0;
        while (!done) begin
            @(negedge clk);
            n++;
            if (rst_main === val || n > maxc) done = 1'b1;
        end
    endtask

    task automatic count_lows(input int cycles, output int lows_main, output int lows_inv);
        lows_main = 0;
        lows_inv = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (rst_main !== 1'b1) lows_main++;
            if (rst_inv !== 1'b1) lows_inv++;
        end
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) @(negedge clk);
    endtask

    initial begin
        int n;
        int lm;
        int li;
        idle(5);
        check("R12 reset output low under arst", int'(rst_main), 0);
        arst_n = 1'b1;
        count_lows(50, lm, li);
        check("R1 output held low while supply bad", lm, 50);

        // power-on release
        supply_ok = 1'b1;
        wait_level(1'b1, 1000, n);
        check("R2 full delay after supply rise", n, T + 3);

        // unused kick: repeated pulses
        wait_level(1'b0, 1000, n);
        check("R4 timeout without kick", n, T);
        wait_level(1'b1, 1000, n);
        check("R4 short pulse length", n, D2);
        wait_level(1'b0, 1000, n);
        check("R5 period repeats with kick low", n, T);
        wait_level(1'b1, 1000, n);

        // qualified kick pulse of exactly KQ cycles
        idle(100);
        kick = 1'b1;
        fork
            begin idle(KQ); kick = 1'b0; end
            wait_level(1'b0, 1000, n);
        join
        check("R3 qualified kick restarts timeout", n, KQ + 3 + T);
        wait_level(1'b1, 1000, n);

        // kick one cycle too short
        idle(100);
        kick = 1'b1;
        fork
            begin idle(KQ - 1); kick = 1'b0; end
            wait_level(1'b0, 1000, n);
        join
        check("R9 short kick ignored", n, T - 100);
        wait_level(1'b1, 1000, n);

        // steady high kick restarts only once
        idle(50);
        kick = 1'b1;
        wait_level(1'b0, 1000, n);
        check("R3 first qualification of held kick", n, KQ + 3 + T);
        wait_level(1'b1, 1000, n);
        check("R4 short pulse with kick high", n, D2);
        wait_level(1'b0, 1000, n);
        check("R3 held kick level does not restart", n, T);
        kick = 1'b0;
        wait_level(1'b1, 1000, n);

        // disable watchdog
        idle(10);
        wd_en = 1'b0;
        count_lows(600, lm, li);
        check("R7 no timeout while disabled", lm, 0);
        check("R11 inverted polarity instance enabled by low", int'(li > 0), 1);

        // short manual request ignored
        mrst_n = 1'b0;
        idle(MQ - 1);
        mrst_n = 1'b1;
        count_lows(300, lm, li);
        check("R10 short manual request ignored", lm, 0);

        // full manual request
        mrst_n = 1'b0;
        wait_level(1'b0, 1000, n);
        check("R6 manual request asserts reset", n, MQ + 3);
        idle(50);
        mrst_n = 1'b1;
        wait_level(1'b1, 1000, n);
        check("R6 full delay after manual release", n, T + 4);

        // re-enable with supply good
        idle(30);
        wd_en = 1'b1;
        wait_level(1'b0, 1000, n);
        check("R8 fresh timeout after enable", n, T + 2);
        wait_level(1'b1, 1000, n);
        check("R4 short pulse after re-enable", n, D2);

        // supply drop while released
        idle(30);
        supply_ok = 1'b0;
        wait_level(1'b0, 1000, n);
        check("R1 supply drop forces reset", n, 3);

        // supply and enable together
        wd_en = 1'b0;
        idle(10);
        supply_ok = 1'b1;
        wd_en = 1'b1;
        wait_level(1'b1, 1000, n);
        check("R8 supply and enable together use full delay", n, T + 3);
        wait_level(1'b0, 1000, n);
        check("R8 timeout after joint power-up", n, T);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule